// File: doc/BRIEF.md
# Flow-Through Burst Memory

A behavioural synchronous burst memory with a read path that has no output pipeline register. Every word is 36 bits wide and is made of four 9-bit lanes. The word count is a parameter. On each rising clock edge the block samples three chip selects, two address strobes, a step input and the write controls. A strobe loads a new external address. A step input then walks the two low address bits through a four-word burst, in either wrapping-increment or XOR order. Reads are combinational from the registered address, so the word appears in the same cycle. Writes commit on the edge, under a per-lane mask.

The bidirectional data bus is split into an input port `d`, an output port `q` and a drive qualifier `q_drive`. An external pad or bus mux is expected to use `q_drive` to enable its drivers. A doze input puts the block into a power-down state after two edges. It leaves that state two edges after doze falls. Memory contents are kept throughout. Control inputs are ignored while doze is high, while the block is powered down and during the recovery edges.

Top module: `fts_burst_ram`

## Requirements
- R1: After a synchronous reset the block is deselected, and `q_drive`, `q` and `dozing` are all 0.
- R2: A strobe that is accepted selects the block only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination deselects it. The chip selects are not looked at on edges where no strobe is accepted.
- R3: An accepted edge with `host_strobe_n`=0 and `sel_a_n`=0 always starts a read, whatever the write controls are. `host_strobe_n` is ignored while `sel_a_n`=1. When both strobes are low and `host_strobe_n` is accepted, it wins.
- R4: When `host_strobe_n` is not accepted and `ctl_strobe_n`=0, the address is loaded. If a write is detected, the word is written on that same edge. Otherwise a read starts.
- R5: A write is detected when `all_wr_n`=0, or when `lane_wr_n`=0 with at least one `lane_sel_n` bit at 0. `all_wr_n`=0 writes all four lanes. Otherwise lane i is written when `lane_sel_n[i]`=0. Lane i is bits `d[9i+8:9i]`, so bit 0 covers bits 8:0 and bit 3 covers bits 35:27.
- R6: On an edge with no accepted strobe while the block is selected, `step_n`=0 advances the 2-bit burst count by one, wrapping from 3 to 0, and `step_n`=1 holds it. The upper address bits stay as loaded.
- R7: The low two address bits are start XOR count when `order_xor`=1, and (start + count) mod 4 when `order_xor`=0.
- R8: Read data is flow-through: after the edge that registers an address, `q` shows that word within the same cycle. Continuing cycles with a write detected write to the current burst address, after any step.
- R9: `q_drive` is 1 only while the latest cycle is a selected read and `out_en_n`=0. It is 0 for any write cycle, whatever `out_en_n` is. `q` is 0 whenever `q_drive` is 0.
- R10: In the first cycle of a read started from a deselected state, `out_en_n` is masked and `q_drive` stays 0.
- R11: `dozing` rises two edges after `doze` is sampled high, and falls two edges after it is sampled low. The block is deselected, and strobes and chip selects are ignored, while doze is high or dozing, and for those two recovery edges. Memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_a_n | input | 1 | Chip select, active low; also gates the host strobe |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| host_strobe_n | input | 1 | Address strobe that always starts a read |
| ctl_strobe_n | input | 1 | Address strobe that may write at once |
| step_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| lane_wr_n | input | 1 | Enables the per-lane selects, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| order_xor | input | 1 | Burst order: 1 XOR, 0 wrapping increment (static) |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| doze | input | 1 | Power-down request, active high |
| addr | input | AW | Word address |
| d | input | 36 | Write data |
| q | output | 36 | Read data, zero when not driven |
| q_drive | output | 1 | Bus drive qualifier for q |
| dozing | output | 1 | Power-down state |

## Verification
The bench builds the block with DEPTH=16. At that size a full reference copy of memory fits in the bench, and every word can be written and then read back through both strobes. All sixteen lane-select masks are applied to one word, including the empty mask, which turns the cycle into a read. Both burst orders are run from each of the four start offsets, past the wrap and into a suspend. Deselect-to-read masking, ignored chip selects, and strobes attempted during doze and its recovery edges each get dedicated sequences.

// File: rtl/fts_pkg.sv
package fts_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef logic [LANES-1:0]  lane_mask_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        K_IDLE  = 2'd0,
        K_READ  = 2'd1,
        K_WRITE = 2'd2
    } cyc_kind_e;

    // low address bits from start offset and burst count
    function automatic logic [1:0] burst_low(input logic use_xor,
                                             input logic [1:0] start,
                                             input logic [1:0] count);
        return use_xor ? (start ^ count) : 2'(start + count);
    endfunction

    // per-lane write enables from the write controls
    function automatic lane_mask_t lane_enables(input logic all_n,
                                                input logic lane_n,
                                                input lane_mask_t sel_n);
        if (!all_n)
            return '1;
        else if (!lane_n)
            return ~sel_n;
        else
            return '0;
    endfunction
endpackage

// File: rtl/fts_doze_seq.sv
module fts_doze_seq (
    input  logic clk,
    input  logic rst,
    input  logic doze,
    output logic hold,
    output logic dozing
);
    logic stage1_q, stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= 1'b0;
            stage2_q <= 1'b0;
        end else begin
            stage1_q <= doze;
            stage2_q <= stage1_q;
        end
    end

    // controls are ignored from the request through the recovery edges
    assign hold   = doze | stage1_q | stage2_q;
    assign dozing = stage2_q;
endmodule

// File: rtl/fts_ctrl.sv
module fts_ctrl
    import fts_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          sel_a_n,
    input  logic          sel_b,
    input  logic          sel_c_n,
    input  logic          host_strobe_n,
    input  logic          ctl_strobe_n,
    input  logic          step_n,
    input  logic          all_wr_n,
    input  logic          lane_wr_n,
    input  lane_mask_t    lane_sel_n,
    input  logic          order_xor,
    input  logic [AW-1:0] addr,
    output logic          wr_go,
    output lane_mask_t    wr_lanes,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          rd_ok,
    output logic          oe_mask
);
    localparam int BASE_W = AW - 2;

    typedef struct packed {
        logic              sel;
        cyc_kind_e         kind;
        logic [BASE_W-1:0] base;
        logic [1:0]        start;
        logic [1:0]        count;
        logic              mask;
    } burst_st_t;

    burst_st_t  st_q, st_n;
    lane_mask_t lanes;
    logic       wr_det, full_sel, host_take, ctl_take, start_take, cont;

    assign lanes      = lane_enables(all_wr_n, lane_wr_n, lane_sel_n);
    assign wr_det     = |lanes;
    assign full_sel   = !sel_a_n && sel_b && !sel_c_n;
    assign host_take  = !hold && !host_strobe_n && !sel_a_n;
    assign ctl_take   = !hold && !host_take && !ctl_strobe_n;
    assign start_take = host_take || ctl_take;
    assign cont       = !hold && !start_take && st_q.sel;

    always_comb begin
        st_n = st_q;
        if (hold) begin
            st_n.sel  = 1'b0;
            st_n.kind = K_IDLE;
            st_n.mask = 1'b0;
        end else if (start_take) begin
            st_n.sel   = full_sel;
            st_n.base  = addr[AW-1:2];
            st_n.start = addr[1:0];
            st_n.count = 2'd0;
            if (!full_sel)
                st_n.kind = K_IDLE;
            else if (ctl_take && wr_det)
                st_n.kind = K_WRITE;
            else
                st_n.kind = K_READ;
            st_n.mask = full_sel && (st_n.kind == K_READ) && !st_q.sel;
        end else if (cont) begin
            if (!step_n)
                st_n.count = 2'(st_q.count + 2'd1);
            st_n.kind = wr_det ? K_WRITE : K_READ;
            st_n.mask = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{sel: 1'b0, kind: K_IDLE, base: '0, start: 2'd0,
                      count: 2'd0, mask: 1'b0};
        end else begin
            st_q <= st_n;
        end
    end

    assign wr_go    = (st_n.kind == K_WRITE) && (start_take || cont);
    assign wr_lanes = lanes;
    assign wr_addr  = {st_n.base, burst_low(order_xor, st_n.start, st_n.count)};
    assign rd_addr  = {st_q.base, burst_low(order_xor, st_q.start, st_q.count)};
    assign rd_ok    = st_q.sel && (st_q.kind == K_READ);
    assign oe_mask  = st_q.mask;

    // R11: any held edge leaves the block deselected
    assert_hold_desel_R11: assert property (@(posedge clk) disable iff (rst)
        hold |=> !st_q.sel);
    // R3: a host-strobe start with full select is a read
    assert_host_read_R3: assert property (@(posedge clk) disable iff (rst)
        (host_take && full_sel) |=> (st_q.kind == K_READ));
    // R4: controller strobe with a detected write writes
    assert_ctl_write_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl_take && full_sel && wr_det) |=> (st_q.kind == K_WRITE));
    // R6: step advances the burst count by one
    assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
        (cont && !step_n) |=> (st_q.count == 2'($past(st_q.count) + 2'd1)));
    // R2: selection only appears through an accepted strobe
    assert_sel_source_R2: assert property (@(posedge clk) disable iff (rst)
        (!st_q.sel && !start_take) |=> !st_q.sel);
endmodule

// File: rtl/fts_lane_mem.sv
module fts_lane_mem
    import fts_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [LANE_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [LANE_W-1:0] rdata
);
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            cells[waddr] <= wdata;
    end

    // flow-through: no output register
    assign rdata = cells[raddr];
endmodule

// File: rtl/fts_burst_ram.sv
module fts_burst_ram
    import fts_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_a_n,
    input  logic          sel_b,
    input  logic          sel_c_n,
    input  logic          host_strobe_n,
    input  logic          ctl_strobe_n,
    input  logic          step_n,
    input  logic          all_wr_n,
    input  logic          lane_wr_n,
    input  logic [3:0]    lane_sel_n,
    input  logic          order_xor,
    input  logic          out_en_n,
    input  logic          doze,
    input  logic [AW-1:0] addr,
    input  logic [35:0]   d,
    output logic [35:0]   q,
    output logic          q_drive,
    output logic          dozing
);
    logic          hold, wr_go, rd_ok, oe_mask;
    lane_mask_t    wr_lanes;
    logic [AW-1:0] wr_addr, rd_addr;
    word_t         rd_word;

    fts_doze_seq u_doze (
        .clk    (clk),
        .rst    (rst),
        .doze   (doze),
        .hold   (hold),
        .dozing (dozing)
    );

    fts_ctrl #(.AW(AW)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .hold          (hold),
        .sel_a_n       (sel_a_n),
        .sel_b         (sel_b),
        .sel_c_n       (sel_c_n),
        .host_strobe_n (host_strobe_n),
        .ctl_strobe_n  (ctl_strobe_n),
        .step_n        (step_n),
        .all_wr_n      (all_wr_n),
        .lane_wr_n     (lane_wr_n),
        .lane_sel_n    (lane_sel_n),
        .order_xor     (order_xor),
        .addr          (addr),
        .wr_go         (wr_go),
        .wr_lanes      (wr_lanes),
        .wr_addr       (wr_addr),
        .rd_addr       (rd_addr),
        .rd_ok         (rd_ok),
        .oe_mask       (oe_mask)
    );

    for (genvar li = 0; li < LANES; li++) begin : g_lane
        fts_lane_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
            .clk   (clk),
            .we    (wr_go && wr_lanes[li]),
            .waddr (wr_addr),
            .wdata (d[li*LANE_W +: LANE_W]),
            .raddr (rd_addr),
            .rdata (rd_word[li*LANE_W +: LANE_W])
        );
    end

    assign q_drive = rd_ok && !oe_mask && !out_en_n;
    assign q       = q_drive ? rd_word : '0;

    // R11: nothing drives the bus while powered down
    assert_doze_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        dozing |-> !q_drive);
    // R1: reset leaves the bus undriven
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !q_drive);
endmodule

// File: tb/fts_burst_ram_tb.sv
module fts_burst_ram_tb;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
    logic host_strobe_n = 1'b1, ctl_strobe_n = 1'b1, step_n = 1'b1;
    logic all_wr_n = 1'b1, lane_wr_n = 1'b1;
    logic [3:0] lane_sel_n = 4'hF;
    logic order_xor = 1'b1, out_en_n = 1'b0, doze = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [35:0] d = '0;
    logic [35:0] q;
    logic q_drive, dozing;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference state
    logic [35:0] ref_mem [DEPTH];
    bit m_sel, m_rd, m_mask, m_z1, m_z2;
    logic [1:0] m_base, m_start, m_count;

    always #2.5 clk = ~clk;

    fts_burst_ram #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .host_strobe_n(host_strobe_n),
        .ctl_strobe_n(ctl_strobe_n), .step_n(step_n), .all_wr_n(all_wr_n),
        .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n), .order_xor(order_xor),
        .out_en_n(out_en_n), .doze(doze), .addr(addr), .d(d), .q(q),
        .q_drive(q_drive), .dozing(dozing)
    );

    function automatic logic [35:0] pat(input int a, input int k);
        return 36'(a * 36'h0_1234_5671 + k * 36'h9_8765_4323 + 36'h0_5A5A_0F0F);
    endfunction

    function automatic logic [AW-1:0] m_addr();
        logic [1:0] lo;
        lo = order_xor ? (m_start ^ m_count) : 2'(m_start + m_count);
        return {m_base, lo};
    endfunction

    task automatic check_now(input string tag);
        bit          e_en;
        logic [35:0] e_q;
        e_en = m_rd && m_sel && !m_mask && !out_en_n;
        e_q  = e_en ? ref_mem[m_addr()] : 36'd0;
        total++;
        if (q_drive !== e_en || q !== e_q || dozing !== m_z2) begin
            bad++;
            $display("FAIL %s: drive=%0b q=%h dozing=%0b expected drive=%0b q=%h dozing=%0b",
                     tag, q_drive, q, dozing, e_en, e_q, m_z2);
        end
    endtask

    // apply current inputs on one edge, update the reference, then check
    task automatic tick(input string tag);
        bit hold, full, htake, ctake, wdet;
        logic [3:0] lanes;
        logic [AW-1:0] wa;
        hold  = doze || m_z1 || m_z2;
        lanes = !all_wr_n ? 4'hF : (!lane_wr_n ? ~lane_sel_n : 4'h0);
        wdet  = |lanes;
        full  = !sel_a_n && sel_b && !sel_c_n;
        htake = !hold && !host_strobe_n && !sel_a_n;
        ctake = !hold && !htake && !ctl_strobe_n;
        if (hold) begin
            m_sel = 0; m_rd = 0; m_mask = 0;
        end else if (htake || ctake) begin
            m_mask  = full && !m_sel && !(ctake && wdet);
            m_sel   = full;
            m_base  = addr[AW-1:2];
            m_start = addr[1:0];
            m_count = 2'd0;
            m_rd    = !(ctake && wdet);
            if (full && ctake && wdet) begin
                wa = m_addr();
                for (int i = 0; i < 4; i++)
                    if (lanes[i]) ref_mem[wa][i*9 +: 9] = d[i*9 +: 9];
            end
        end else if (m_sel) begin
            if (!step_n) m_count = 2'(m_count + 2'd1);
            m_rd   = !wdet;
            m_mask = 0;
            if (wdet) begin
                wa = m_addr();
                for (int i = 0; i < 4; i++)
                    if (lanes[i]) ref_mem[wa][i*9 +: 9] = d[i*9 +: 9];
            end
        end
        m_z2 = m_z1;
        m_z1 = doze;
        @(posedge clk);
        #1;
        check_now(tag);
    endtask

    task automatic quiet();
        host_strobe_n = 1; ctl_strobe_n = 1; step_n = 1;
        all_wr_n = 1; lane_wr_n = 1; lane_sel_n = 4'hF;
    endtask

    task automatic select_on();
        sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 36'd0;
        m_sel = 0; m_rd = 0; m_mask = 0; m_z1 = 0; m_z2 = 0;
        m_base = 0; m_start = 0; m_count = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check_now("R1");
        rst = 0;

        // R4: controller-strobe writes fill every word on the loading edge
        for (int a = 0; a < DEPTH; a++) begin
            quiet(); select_on();
            ctl_strobe_n = 0; all_wr_n = 0; addr = AW'(a); d = pat(a, 0);
            tick("R4");
        end
        // R8: flow-through readback through the host strobe
        for (int a = 0; a < DEPTH; a++) begin
            quiet(); host_strobe_n = 0; addr = AW'(a);
            tick("R8");
        end

        // R3: host strobe ignores write controls and wins over the other strobe
        quiet(); host_strobe_n = 0; ctl_strobe_n = 0; all_wr_n = 0;
        addr = 3; d = 36'hF_FFFF_FFFF;
        tick("R3");
        quiet();
        tick("R3");
        // R3: host strobe ignored while sel_a_n is high; burst continues
        sel_a_n = 1; host_strobe_n = 0; addr = 9;
        tick("R3");
        quiet(); select_on();

        // R5: every lane mask on word 5 (empty mask becomes a read)
        for (int m = 0; m < 16; m++) begin
            quiet(); ctl_strobe_n = 0; lane_wr_n = 0; lane_sel_n = ~4'(m);
            addr = 5; d = pat(5, m + 1);
            tick("R5");
            quiet(); host_strobe_n = 0; addr = 5;
            tick("R5");
        end
        // R5: all-lane write overrides lane selects
        quiet(); ctl_strobe_n = 0; all_wr_n = 0; lane_wr_n = 1; lane_sel_n = 4'hF;
        addr = 6; d = pat(6, 7);
        tick("R5");
        quiet(); host_strobe_n = 0; addr = 6;
        tick("R5");

        // R6 R7: both orders from every start offset, wrap, then suspend
        for (int mo = 0; mo < 2; mo++) begin
            for (int s = 0; s < 4; s++) begin
                order_xor = mo[0];
                quiet(); host_strobe_n = 0; addr = AW'(8 + s);
                tick("R7");
                quiet(); step_n = 0;
                for (int k = 0; k < 4; k++) tick("R6");
                step_n = 1;
                tick("R6");
            end
        end
        order_xor = 1;

        // R8: burst continuation writes at the current burst address
        quiet(); host_strobe_n = 0; addr = 12;
        tick("R8");
        quiet(); all_wr_n = 0; d = pat(12, 9);
        tick("R8");
        step_n = 0; d = pat(13, 9);
        tick("R9");
        d = pat(14, 9);
        tick("R9");
        for (int a = 12; a < 15; a++) begin
            quiet(); host_strobe_n = 0; addr = AW'(a);
            tick("R8");
        end

        // R2: controller strobe without full select deselects
        quiet(); ctl_strobe_n = 0; sel_b = 0; addr = 2;
        tick("R2");
        // R10: first read after deselect is masked
        quiet(); select_on(); host_strobe_n = 0; addr = 2;
        tick("R10");
        // R2: selects ignored on a continuing edge
        quiet(); sel_b = 0; sel_c_n = 1;
        tick("R10");
        // R9: output enable high stops the drive
        out_en_n = 1;
        #1 check_now("R9");
        out_en_n = 0;
        #1 check_now("R9");
        // R2: host strobe with sel_c_n high deselects
        quiet(); sel_b = 1; host_strobe_n = 0; addr = 7;
        tick("R2");

        // R11: doze sequence with strobes attempted throughout
        quiet(); select_on(); host_strobe_n = 0; addr = 1;
        tick("R11");
        quiet();
        tick("R11");
        doze = 1;
        tick("R11");
        tick("R11");
        ctl_strobe_n = 0; all_wr_n = 0; addr = 0; d = 36'h1_1111_1111;
        tick("R11");
        doze = 0;
        tick("R11");
        addr = 4; d = 36'h2_2222_2222;
        tick("R11");
        quiet();
        tick("R11");
        host_strobe_n = 0; addr = 0;
        tick("R11");
        quiet();
        tick("R11");
        host_strobe_n = 0; addr = 4;
        tick("R11");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule